// File: doc/BRIEF.md
# Short-Descriptor Access Permission Checker

This block decides, for one memory access at a time, whether the access is allowed under the legacy 32-bit translation scheme or which kind of fault it raises. Each request presents the already-fetched translation entry attributes (domain number, access-permission bits, execute-never bits, format flag, second-stage permission bits) together with the current access-control word, the requester's privilege, the access kind and the relevant system control bits.

The decision is purely combinational inside and is registered once. One cycle after a request strobe the block raises a one-cycle done pulse and presents a two-bit fault code: no fault, domain fault, prefetch abort or data abort. Table walking, entry storage and fault-status encoding sit in neighbouring blocks.

Top module: `ap_perm_check`

## Requirements
- R1: `done_o` is high in the cycle after each cycle with `valid_i` high and low otherwise; `fault_code_o` is 0 whenever `done_o` is low; reset (active-low `rst_ni`) clears both.
- R2: For short-format entries the domain field is bits [2*d+1:2*d] of `dac_i`, with d = `domain_i`; field 0 or 2 gives a domain fault (code 1), field 3 gives no fault of any kind, field 1 applies the permission checks below.
- R3: For long-format entries (`long_fmt_i`=1) the domain field is ignored and the permission checks always apply.
- R4: The effective 3-bit AP value is {`ap_i`[1:0],1} for long format; for short format it is `ap_i` with bit 0 forced to 1 when `afe_i` is set, else `ap_i` unchanged.
- R5: With `kind_i` encoded 0 read, 1 write, 2 fetch, 3 read: effective AP 1 aborts unprivileged accesses; AP 2 aborts unprivileged writes; AP 3 never aborts; AP 5 aborts unprivileged accesses and all writes.
- R6: Effective AP 0 uses `sr_i`: 1 aborts writes and unprivileged accesses, 2 aborts writes, 0 and 3 abort every access; effective AP 4, 6 and 7 abort every access.
- R7: The page is writable for AP 1 or 3, and for AP 2 when privileged; execute-never holds when `xn_i` is set, or the page is writable and `wxn_i` is set, or AP is 3 with `uwxn_i` and `priv_i` set.
- R8: A fetch gives a prefetch abort (code 2) if the AP check aborts, execute-never holds, a long-format entry has `pxn_i` set for a privileged fetch, or a second-stage fetch lacks `hap_i`[0].
- R9: With `stage2_i` set the AP abort is not applied; a write needs `hap_i`[1] and a read or fetch needs `hap_i`[0].
- R10: A read or write gives a data abort (code 3) on an AP abort or a missing second-stage grant, and never a prefetch abort; a fetch never gives a data abort.
- R11: A domain fault takes precedence over every permission fault on the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; inputs sampled when high |
| domain_i | input | DOMAIN_W | Domain number of the entry |
| dac_i | input | 2*2^DOMAIN_W | Domain access control word |
| ap_i | input | 3 | Access-permission bits of the entry |
| xn_i | input | 1 | Entry execute-never |
| pxn_i | input | 1 | Entry privileged execute-never |
| long_fmt_i | input | 1 | Entry uses the long descriptor format |
| stage2_i | input | 1 | Second-stage check |
| hap_i | input | 2 | Second-stage grants: bit 1 write, bit 0 read |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| priv_i | input | 1 | Privileged access |
| wxn_i | input | 1 | Writable implies execute-never |
| uwxn_i | input | 1 | Unprivileged-writable implies privileged execute-never |
| afe_i | input | 1 | Simplified AP model, forces AP bit 0 |
| sr_i | input | 2 | Legacy system/ROM protection bits for AP 0 |
| done_o | output | 1 | One-cycle result pulse |
| fault_code_o | output | 2 | 0 none, 1 domain, 2 prefetch abort, 3 data abort |

## Verification
The domain decision and the permission decision fall in the same cycle whenever a short-format entry meets a no-access or reserved domain field while its AP, execute-never or privileged-execute-never bits would also fault. The bench provokes this by sweeping every domain field value against every AP value, access kind, privilege and control-bit combination, with the domain number rotating so the field sits at each slice of the control word. The outcome is judged by the code alone: any domain fault must show code 1, never the abort the permission path would have raised.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_DOMAIN = 2'd1,
    FC_PABT   = 2'd2,
    FC_DABT   = 2'd3
  } fault_code_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_READ2 = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    DOM_NOACC   = 2'd0,
    DOM_CLIENT  = 2'd1,
    DOM_RSVD    = 2'd2,
    DOM_MANAGER = 2'd3
  } dom_class_e;
endpackage

// File: rtl/perm_domain_check.sv
module perm_domain_check #(
  parameter int DOMAIN_W = 4,
  localparam int NUM_DOM = 1 << DOMAIN_W,
  localparam int DAC_W   = 2 * NUM_DOM
) (
  input  logic [DOMAIN_W-1:0] domain_i,
  input  logic [DAC_W-1:0]    dac_i,
  input  logic                long_fmt_i,
  output logic                dom_fault_o,
  output logic                dom_manager_o
);
  import perm_pkg::*;

  logic [1:0] field_a [NUM_DOM];
  logic [1:0] sel_field;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign field_a[g] = dac_i[2*g +: 2];
  end

  assign sel_field = field_a[domain_i];

  always_comb begin
    dom_fault_o   = 1'b0;
    dom_manager_o = 1'b0;
    if (!long_fmt_i) begin
      unique case (dom_class_e'(sel_field))
        DOM_NOACC, DOM_RSVD: dom_fault_o   = 1'b1;
        DOM_MANAGER:         dom_manager_o = 1'b1;
        default:             ;
      endcase
    end
  end
endmodule

// File: rtl/perm_ap_decode.sv
module perm_ap_decode #(
  parameter int AP_W = 3
) (
  input  logic [AP_W-1:0] ap_i,
  input  logic            long_fmt_i,
  input  logic            afe_i,
  input  logic [1:0]      sr_i,
  input  logic            priv_i,
  input  logic            is_write_i,
  output logic [AP_W-1:0] ap_eff_o,
  output logic            ap_abort_o,
  output logic            writable_o
);
  logic [AP_W-1:0] ap_shift;

  assign ap_shift = long_fmt_i ? {ap_i[AP_W-2:0], 1'b0} : ap_i;
  assign ap_eff_o = (long_fmt_i || afe_i) ? (ap_shift | AP_W'(1)) : ap_shift;

  always_comb begin
    ap_abort_o = 1'b1;
    writable_o = 1'b0;
    unique case (ap_eff_o)
      AP_W'(0): begin
        // legacy protection bits decide
        unique case (sr_i)
          2'd1:    ap_abort_o = is_write_i || !priv_i;
          2'd2:    ap_abort_o = is_write_i;
          default: ap_abort_o = 1'b1;
        endcase
      end
      AP_W'(1): begin
        ap_abort_o = !priv_i;
        writable_o = 1'b1;
      end
      AP_W'(2): begin
        ap_abort_o = !priv_i && is_write_i;
        writable_o = priv_i;
      end
      AP_W'(3): begin
        ap_abort_o = 1'b0;
        writable_o = 1'b1;
      end
      AP_W'(5): ap_abort_o = !priv_i || is_write_i;
      default:  ap_abort_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/perm_fault_select.sv
module perm_fault_select #(
  parameter int AP_W = 3
) (
  input  logic [AP_W-1:0] ap_eff_i,
  input  logic            ap_abort_i,
  input  logic            writable_i,
  input  logic            dom_fault_i,
  input  logic            dom_manager_i,
  input  logic            xn_i,
  input  logic            pxn_i,
  input  logic            long_fmt_i,
  input  logic            stage2_i,
  input  logic [1:0]      hap_i,
  input  logic [1:0]      kind_i,
  input  logic            priv_i,
  input  logic            wxn_i,
  input  logic            uwxn_i,
  output logic [1:0]      code_o
);
  import perm_pkg::*;

  logic is_fetch, is_write, abt, hap_ok, xn_eff, fetch_bad, data_bad;

  assign is_fetch  = acc_kind_e'(kind_i) == ACC_FETCH;
  assign is_write  = acc_kind_e'(kind_i) == ACC_WRITE;
  assign abt       = ap_abort_i && !stage2_i;
  assign hap_ok    = !stage2_i || (is_write ? hap_i[1] : hap_i[0]);
  assign xn_eff    = xn_i || (writable_i && wxn_i) ||
                     (ap_eff_i == AP_W'(3) && uwxn_i && priv_i);
  assign fetch_bad = abt || xn_eff || (long_fmt_i && pxn_i && priv_i) || !hap_ok;
  assign data_bad  = abt || !hap_ok;

  always_comb begin
    if (dom_fault_i)        code_o = FC_DOMAIN;
    else if (dom_manager_i) code_o = FC_NONE;
    else if (is_fetch)      code_o = fetch_bad ? FC_PABT : FC_NONE;
    else                    code_o = data_bad ? FC_DABT : FC_NONE;
  end
endmodule

// File: rtl/ap_perm_check.sv
module ap_perm_check #(
  parameter int DOMAIN_W = 4,
  parameter int AP_W     = 3,
  localparam int DAC_W   = 2 << DOMAIN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DOMAIN_W-1:0] domain_i,
  input  logic [DAC_W-1:0]    dac_i,
  input  logic [AP_W-1:0]     ap_i,
  input  logic                xn_i,
  input  logic                pxn_i,
  input  logic                long_fmt_i,
  input  logic                stage2_i,
  input  logic [1:0]          hap_i,
  input  logic [1:0]          kind_i,
  input  logic                priv_i,
  input  logic                wxn_i,
  input  logic                uwxn_i,
  input  logic                afe_i,
  input  logic [1:0]          sr_i,
  output logic                done_o,
  output logic [1:0]          fault_code_o
);
  import perm_pkg::*;

  logic            dom_fault, dom_manager, ap_abort, writable;
  logic [AP_W-1:0] ap_eff;
  logic [1:0]      code_d;
  logic            done_q;
  logic [1:0]      code_q;

  perm_domain_check #(.DOMAIN_W(DOMAIN_W)) u_dom (
    .domain_i      (domain_i),
    .dac_i         (dac_i),
    .long_fmt_i    (long_fmt_i),
    .dom_fault_o   (dom_fault),
    .dom_manager_o (dom_manager)
  );

  perm_ap_decode #(.AP_W(AP_W)) u_ap (
    .ap_i       (ap_i),
    .long_fmt_i (long_fmt_i),
    .afe_i      (afe_i),
    .sr_i       (sr_i),
    .priv_i     (priv_i),
    .is_write_i (acc_kind_e'(kind_i) == ACC_WRITE),
    .ap_eff_o   (ap_eff),
    .ap_abort_o (ap_abort),
    .writable_o (writable)
  );

  perm_fault_select #(.AP_W(AP_W)) u_sel (
    .ap_eff_i      (ap_eff),
    .ap_abort_i    (ap_abort),
    .writable_i    (writable),
    .dom_fault_i   (dom_fault),
    .dom_manager_i (dom_manager),
    .xn_i          (xn_i),
    .pxn_i         (pxn_i),
    .long_fmt_i    (long_fmt_i),
    .stage2_i      (stage2_i),
    .hap_i         (hap_i),
    .kind_i        (kind_i),
    .priv_i        (priv_i),
    .wxn_i         (wxn_i),
    .uwxn_i        (uwxn_i),
    .code_o        (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      code_q <= FC_NONE;
    end else begin
      done_q <= valid_i;
      code_q <= valid_i ? code_d : FC_NONE;
    end
  end

  assign done_o       = done_q;
  assign fault_code_o = code_q;

  a_r1_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && fault_code_o == 2'd0));
  a_r2_noacc_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_fmt_i && ((dac_i >> (2 * domain_i)) & DAC_W'(3)) == DAC_W'(0))
    |=> fault_code_o == 2'd1);
  a_r2_manager_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_fmt_i && ((dac_i >> (2 * domain_i)) & DAC_W'(3)) == DAC_W'(3))
    |=> fault_code_o == 2'd0);
  a_r3_long_no_domain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && long_fmt_i) |=> fault_code_o != 2'd1);
  a_r10_fetch_no_dabt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd2) |=> fault_code_o != 2'd3);
  a_r10_data_no_pabt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i != 2'd2) |=> fault_code_o != 2'd2);
endmodule

// File: tb/tb_ap_perm_check.sv
module tb_ap_perm_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  domain_i = '0;
  logic [31:0] dac_i = '0;
  logic [2:0]  ap_i = '0;
  logic        xn_i = 0, pxn_i = 0, long_fmt_i = 0, stage2_i = 0;
  logic [1:0]  hap_i = '0, kind_i = '0, sr_i = '0;
  logic        priv_i = 0, wxn_i = 0, uwxn_i = 0, afe_i = 0;
  logic        done_o;
  logic [1:0]  fault_code_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  ap_perm_check dut (.*);

  // reference outcome from the requirements
  function automatic logic [1:0] model(input logic [1:0] df, input logic lg,
      input logic [2:0] ap, input logic [1:0] k, input logic pv, input logic x,
      input logic px, input logic wx, input logic ux, input logic af,
      input logic [1:0] sr, input logic s2, input logic [1:0] hp);
    int e; bit wr, fe, abt, wrt, xnv, hok;
    wr = (k == 1); fe = (k == 2);
    if (!lg && (df == 0 || df == 2)) return 2'd1;          // R2, R11
    if (!lg && df == 3) return 2'd0;                       // R2
    e = lg ? ((ap % 4) * 2 + 1) : (af ? (ap | 1) : ap);    // R4
    wrt = 0;
    case (e)                                               // R5, R6
      0: abt = (sr == 1) ? (wr || !pv) : (sr == 2) ? wr : 1;
      1: begin abt = !pv; wrt = 1; end
      2: begin abt = !pv && wr; wrt = pv; end
      3: begin abt = 0; wrt = 1; end
      5: abt = !pv || wr;
      default: abt = 1;
    endcase
    if (s2) abt = 0;                                       // R9
    hok = !s2 || (wr ? hp[1] : hp[0]);
    xnv = x || (wrt && wx) || (e == 3 && ux && pv);        // R7
    if (fe) return (abt || xnv || (lg && px && pv) || !hok) ? 2'd2 : 2'd0; // R8
    return (abt || !hok) ? 2'd3 : 2'd0;                    // R10
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: code=%0d expected %0d (ap=%0d long=%0d kind=%0d priv=%0d s2=%0d)",
               tag, act, exp, ap_i, long_fmt_i, kind_i, priv_i, stage2_i);
    end
  endtask

  task automatic chk_done(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: done=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] df, input logic lg, input logic [2:0] ap,
      input logic [1:0] k, input logic [5:0] fl, input logic [1:0] sr,
      input logic s2, input logic [1:0] hp, input logic [3:0] dom);
    logic [31:0] w;
    w = $urandom;
    w[2*dom +: 2] = df;
    domain_i = dom; dac_i = w; long_fmt_i = lg; ap_i = ap; kind_i = k;
    {priv_i, xn_i, pxn_i, wxn_i, uwxn_i, afe_i} = fl;
    sr_i = sr; stage2_i = s2; hap_i = hp; valid_i = 1'b1;
  endtask

  task automatic run_one(input string tag, input logic [1:0] df, input logic lg,
      input logic [2:0] ap, input logic [1:0] k, input logic [5:0] fl,
      input logic [1:0] sr, input logic s2, input logic [1:0] hp, input logic [3:0] dom);
    logic [1:0] e;
    drive(df, lg, ap, k, fl, sr, s2, hp, dom);
    e = model(df, lg, ap, k, fl[5], fl[4], fl[3], fl[2], fl[1], fl[0], sr, s2, hp);
    @(negedge clk_i);
    chk_done({tag, " R1"}, done_o, 1'b1);
    chk(tag, fault_code_o, e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 190000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int idx;
    string tg;
    idx = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk_done("R1 reset", done_o, 1'b0);
    chk("R1 reset", fault_code_o, 2'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_done("R1 idle", done_o, 1'b0);

    // R11: domain fault over a fetch that would also be execute-never and AP-abort
    run_one("R11 domain over pabt", 2'd0, 0, 3'd1, 2'd2, 6'b010000, 2'd0, 0, 2'd0, 4'd9);
    // R4: afe makes AP 2 act as 3 for an unprivileged read
    run_one("R4 afe", 2'd1, 0, 3'd2, 2'd0, 6'b000001, 2'd0, 0, 2'd0, 4'd3);
    chk("R4 afe grants", fault_code_o, 2'd0);
    // R7: writable page with wxn blocks fetch
    run_one("R7 wxn", 2'd1, 0, 3'd3, 2'd2, 6'b100100, 2'd0, 0, 2'd0, 4'd15);
    chk("R7 wxn pabt", fault_code_o, 2'd2);
    // R9, R10: second stage write without write grant
    run_one("R9 hap write", 2'd1, 1, 3'd1, 2'd1, 6'b100000, 2'd0, 1, 2'd1, 4'd0);
    chk("R10 hap dabt", fault_code_o, 2'd3);

    // gap: done must drop
    valid_i = 1'b0;
    @(negedge clk_i);
    chk_done("R1 gap", done_o, 1'b0);
    chk("R1 gap code", fault_code_o, 2'd0);

    // sweep A: first stage, every field, format, AP, kind, flag and sr value
    for (int df = 0; df < 4; df++)
      for (int lg = 0; lg < 2; lg++)
        for (int ap = 0; ap < 8; ap++)
          for (int k = 0; k < 4; k++)
            for (int fl = 0; fl < 64; fl++)
              for (int sr = 0; sr < 4; sr++) begin
                if (!lg && df != 1) tg = "R2";
                else if (lg) tg = "R3";
                else if (k == 2) tg = "R8";
                else if (ap == 0 || ap == 4 || ap > 5) tg = "R6";
                else tg = "R5";
                run_one(tg, 2'(df), 1'(lg), 3'(ap), 2'(k), 6'(fl), 2'(sr), 0, 2'(idx),
                        4'(idx));
                idx++;
              end

    // sweep B: second stage, long format
    for (int ap = 0; ap < 8; ap++)
      for (int k = 0; k < 4; k++)
        for (int fl = 0; fl < 32; fl++)
          for (int hp = 0; hp < 4; hp++) begin
            run_one("R9", 2'd1, 1, 3'(ap), 2'(k), {5'(fl), 1'b0}, 2'(hp), 1, 2'(hp),
                    4'(idx));
            idx++;
          end

    valid_i = 1'b0;
    @(negedge clk_i);
    chk_done("R1 end", done_o, 1'b0);
    finish_run();
  end
endmodule